// File: doc/BRIEF.md
# Debug Port Memory-Read Command Engine

This block sits behind the serial shifter of a debug port. It takes 16-bit command and operand words from the host and carries out two kinds of command. A memory read fetches a byte, a word or a longword from a 32-bit address. A register write loads a 32-bit value into one of the core's address or data registers. Words come in on a valid/ready stream. Every operand and every result moves as two 16-bit halves, with the upper half first.

Toward the system the block is a single-beat bus master. It presents an address, a size and a read or write strobe, and it holds the strobe until the far side answers with done, together with a bus-error flag when the access failed. The results go back to the host as 17-bit response words: a status flag plus 16 data bits. While an access is still outstanding, the response port offers a "not ready" word. The host may poll and pop that word as often as it likes without losing the real result.

Top module: `dbg_cmd_engine`

## Requirements
- R1: A word with 0x1 in bits 15:12, 0x9 in bits 11:8 and 0x0 in bits 3:0 starts a memory read. Bits 7:4 give the size: 0x0 is byte, 0x4 is word and 0x8 is longword. The next two accepted words are the address, bits 31:16 first. Then `busRead` rises and stays high, with a stable address and size, through the cycle in which `busDone` is seen. On `busSize`, 0 means byte, 1 means word and 2 means longword.
- R2: The block clears address bit 0 for word reads and bits 1:0 for longword reads. A byte read passes the address on unchanged.
- R3: A byte read answers with a single word: flag 0, the byte in bits 7:0 and zeros in bits 15:8.
- R4: A word read answers with a single word: flag 0 and bus data bits 15:0. A longword read answers with two flag-0 words, data bits 31:16 first and then bits 15:0.
- R5: A word with 0x2 in bits 15:12, 0x8 in bits 11:8 and 0x0 in bits 7:4 is a register write. Bit 3 selects an address register (1) or a data register (0), and bits 2:0 give the register number. The two operand words that follow form the 32-bit value, upper half first. `busWrite` then carries the value on `busWdata`, `{bit3, bits2:0}` on `busAddr[3:0]` with the upper address bits at zero, and size 2. `busRead` and `busWrite` are never high together.
- R6: A register write that finishes without error answers with a single word: flag 0 and data 0xFFFF.
- R7: While a strobe is outstanding, the response port offers flag 1 with data 0x0000 and no command word is accepted. Popping this word has no effect on the result that follows.
- R8: An access that ends with `busErr` high in the `busDone` cycle answers with a single word, flag 1 and data 0x0001, in place of any data. The block then waits for a new command.
- R9: Any other command word issues no bus access and answers with flag 1 and data 0xFFFF. The block then waits for a new command.
- R10: A response word stays unchanged until the host pops it. While the block waits for a command or an operand, `rspValid` is low. After the last word of a response is popped, `cmdReady` is high.
- R11: After reset, `cmdReady` is high, and `rspValid`, `busRead` and `busWrite` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Host offers a command or operand word |
| cmdReady | output | 1 | Engine accepts a command or operand word |
| cmdWord | input | 16 | Command or operand word |
| rspValid | output | 1 | A response word is offered |
| rspReady | input | 1 | Host pops the response word |
| rspFlag | output | 1 | Status flag of the response word |
| rspData | output | 16 | Response data bits |
| busAddr | output | 32 | Memory address or register index |
| busSize | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| busRead | output | 1 | Memory read strobe, held until done |
| busWrite | output | 1 | Register write strobe, held until done |
| busWdata | output | 32 | Register write value |
| busRdata | input | 32 | Read data, sampled with busDone |
| busDone | input | 1 | Access finished this cycle |
| busErr | input | 1 | Access failed; valid with busDone |

## Verification
Completion of a bus access can land in the same cycle as the host popping a "not ready" poll word. When it does, the pop has to be dropped and the captured result kept for the next slot. The bench answers each access after a random delay of zero to three cycles, including the cycle in which the strobe first appears. On every "not ready" word it pops at random, so this coincidence comes up many times. It is judged by comparing every later response word, and the returned word count, against values computed from an address-hash memory model in the bench.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  localparam int WORD_W    = 16;
  localparam int LONG_W    = 2 * WORD_W;
  localparam int RSP_W     = WORD_W + 1;
  localparam int SIZE_W    = 2;
  localparam int REG_IDX_W = 4;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_LONG = 2'd2;

  // response words: {flag, data}
  localparam logic [RSP_W-1:0] RSP_NOT_READY = {1'b1, 16'h0000};
  localparam logic [RSP_W-1:0] RSP_BUS_ERR   = {1'b1, 16'h0001};
  localparam logic [RSP_W-1:0] RSP_ILLEGAL   = {1'b1, 16'hFFFF};
  localparam logic [RSP_W-1:0] RSP_COMPLETE  = {1'b0, 16'hFFFF};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP_HI,
    ST_OP_LO,
    ST_BUS,
    ST_RSP_HI,
    ST_RSP_LO
  } eng_state_t;

  typedef enum logic [1:0] {
    SEL_BUSY,
    SEL_HI,
    SEL_LO
  } rsp_sel_t;

  typedef struct packed {
    logic     latchCmd;
    logic     latchHi;
    logic     latchLo;
    logic     capture;
    logic     setIllegal;
    rsp_sel_t rspSel;
  } dp_ctl_t;

  function automatic logic isReadCmd(input logic [WORD_W-1:0] w);
    return (w[15:12] == 4'h1) && (w[11:8] == 4'h9) && (w[3:0] == 4'h0) &&
           ((w[7:4] == 4'h0) || (w[7:4] == 4'h4) || (w[7:4] == 4'h8));
  endfunction

  function automatic logic isRegWrCmd(input logic [WORD_W-1:0] w);
    return (w[15:12] == 4'h2) && (w[11:8] == 4'h8) && (w[7:4] == 4'h0);
  endfunction

  function automatic logic [SIZE_W-1:0] readSize(input logic [WORD_W-1:0] w);
    case (w[7:4])
      4'h4:    return SZ_WORD;
      4'h8:    return SZ_LONG;
      default: return SZ_BYTE;
    endcase
  endfunction

  function automatic logic [LONG_W-1:0] alignAddr(input logic [LONG_W-1:0] a,
                                                  input logic [SIZE_W-1:0] sz);
    case (sz)
      SZ_WORD: return {a[LONG_W-1:1], 1'b0};
      SZ_LONG: return {a[LONG_W-1:2], 2'b00};
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic              rspReady,
  input  logic              busDone,
  input  logic              busErr,
  output logic              cmdReady,
  output logic              rspValid,
  output logic              busRead,
  output logic              busWrite,
  output dp_ctl_t           ctl
);

  eng_state_t state, stateNxt;
  logic       isWrQ, isLongQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrQ   <= 1'b0;
      isLongQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.latchCmd) begin
        isWrQ   <= isRegWrCmd(cmdWord);
        isLongQ <= isReadCmd(cmdWord) && (readSize(cmdWord) == SZ_LONG);
      end
    end
  end

  always_comb begin
    stateNxt = state;
    cmdReady = 1'b0;
    rspValid = 1'b0;
    busRead  = 1'b0;
    busWrite = 1'b0;
    ctl      = '{latchCmd: 1'b0, latchHi: 1'b0, latchLo: 1'b0, capture: 1'b0,
                 setIllegal: 1'b0, rspSel: SEL_BUSY};
    case (state)
      ST_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          ctl.latchCmd = 1'b1;
          if (isReadCmd(cmdWord) || isRegWrCmd(cmdWord)) begin
            stateNxt = ST_OP_HI;
          end else begin
            ctl.setIllegal = 1'b1;
            stateNxt       = ST_RSP_LO;
          end
        end
      end
      ST_OP_HI: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          ctl.latchHi = 1'b1;
          stateNxt    = ST_OP_LO;
        end
      end
      ST_OP_LO: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          ctl.latchLo = 1'b1;
          stateNxt    = ST_BUS;
        end
      end
      ST_BUS: begin
        rspValid   = 1'b1;
        ctl.rspSel = SEL_BUSY;
        busRead    = !isWrQ;
        busWrite   = isWrQ;
        if (busDone) begin
          ctl.capture = 1'b1;
          stateNxt    = (!busErr && !isWrQ && isLongQ) ? ST_RSP_HI : ST_RSP_LO;
        end
      end
      ST_RSP_HI: begin
        rspValid   = 1'b1;
        ctl.rspSel = SEL_HI;
        if (rspReady) stateNxt = ST_RSP_LO;
      end
      ST_RSP_LO: begin
        rspValid   = 1'b1;
        ctl.rspSel = SEL_LO;
        if (rspReady) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dbg_cmd_dp.sv
module dbg_cmd_dp
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic [LONG_W-1:0] busRdata,
  input  logic              busErr,
  output logic [LONG_W-1:0] busAddr,
  output logic [SIZE_W-1:0] busSize,
  output logic [LONG_W-1:0] busWdata,
  output logic              rspFlag,
  output logic [WORD_W-1:0] rspData
);

  logic [SIZE_W-1:0]    sizeQ;
  logic                 isWrQ;
  logic [REG_IDX_W-1:0] regIdxQ;
  logic [WORD_W-1:0]    opHiQ;
  logic [LONG_W-1:0]    opQ;
  logic [RSP_W-1:0]     hiRspQ, loRspQ, rspMux;
  logic [LONG_W-1:0]    opFull;
  logic [RSP_W-1:0]     loRspNxt;

  assign opFull = {opHiQ, cmdWord};

  always_comb begin
    if (busErr)              loRspNxt = RSP_BUS_ERR;
    else if (isWrQ)          loRspNxt = RSP_COMPLETE;
    else if (sizeQ == SZ_BYTE)
      loRspNxt = {1'b0, {(WORD_W-8){1'b0}}, busRdata[7:0]};
    else
      loRspNxt = {1'b0, busRdata[WORD_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ   <= SZ_BYTE;
      isWrQ   <= 1'b0;
      regIdxQ <= '0;
      opHiQ   <= '0;
      opQ     <= '0;
      hiRspQ  <= RSP_NOT_READY;
      loRspQ  <= RSP_NOT_READY;
    end else begin
      if (ctl.latchCmd) begin
        isWrQ   <= isRegWrCmd(cmdWord);
        sizeQ   <= isRegWrCmd(cmdWord) ? SZ_LONG : readSize(cmdWord);
        regIdxQ <= cmdWord[REG_IDX_W-1:0];
      end
      if (ctl.latchHi) opHiQ <= cmdWord;
      if (ctl.latchLo) opQ <= isWrQ ? opFull : alignAddr(opFull, sizeQ);
      if (ctl.capture) begin
        hiRspQ <= {1'b0, busRdata[LONG_W-1:WORD_W]};
        loRspQ <= loRspNxt;
      end else if (ctl.setIllegal) begin
        loRspQ <= RSP_ILLEGAL;
      end
    end
  end

  assign busAddr  = isWrQ ? {{(LONG_W-REG_IDX_W){1'b0}}, regIdxQ} : opQ;
  assign busSize  = sizeQ;
  assign busWdata = isWrQ ? opQ : '0;

  always_comb begin
    case (ctl.rspSel)
      SEL_HI:  rspMux = hiRspQ;
      SEL_LO:  rspMux = loRspQ;
      default: rspMux = RSP_NOT_READY;
    endcase
  end

  assign rspFlag = rspMux[RSP_W-1];
  assign rspData = rspMux[WORD_W-1:0];

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [WORD_W-1:0] cmdWord,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspFlag,
  output logic [WORD_W-1:0] rspData,
  output logic [LONG_W-1:0] busAddr,
  output logic [SIZE_W-1:0] busSize,
  output logic              busRead,
  output logic              busWrite,
  output logic [LONG_W-1:0] busWdata,
  input  logic [LONG_W-1:0] busRdata,
  input  logic              busDone,
  input  logic              busErr
);

  dp_ctl_t ctl;

  dbg_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord),
    .rspReady (rspReady),
    .busDone  (busDone),
    .busErr   (busErr),
    .cmdReady (cmdReady),
    .rspValid (rspValid),
    .busRead  (busRead),
    .busWrite (busWrite),
    .ctl      (ctl)
  );

  dbg_cmd_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cmdWord  (cmdWord),
    .busRdata (busRdata),
    .busErr   (busErr),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWdata (busWdata),
    .rspFlag  (rspFlag),
    .rspData  (rspData)
  );

endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic        rspFlag,
  input logic [15:0] rspData,
  input logic [31:0] busAddr,
  input logic [1:0]  busSize,
  input logic        busRead,
  input logic        busWrite,
  input logic        busDone
);

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !busDone) |=> busRead && $stable(busAddr) && $stable(busSize)); // R1

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busSize == 2'd1) |-> !busAddr[0]); // R2

  AST_LONG_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busSize == 2'd2) |-> busAddr[1:0] == 2'b00); // R2

  AST_REG_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> (busAddr[31:4] == 28'd0) && (busSize == 2'd2)); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (busRead || busWrite) |-> rspValid && rspFlag && (rspData == 16'h0000) && !cmdReady); // R7

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady && !busRead && !busWrite)
      |=> rspValid && $stable(rspFlag) && $stable(rspData)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !rspValid); // R10

endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdReady (cmdReady),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspFlag  (rspFlag),
  .rspData  (rspData),
  .busAddr  (busAddr),
  .busSize  (busSize),
  .busRead  (busRead),
  .busWrite (busWrite),
  .busDone  (busDone)
);

// File: tb/sim_dbg_cmd_engine.sv
module sim_dbg_cmd_engine;

  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [15:0] cmdWord = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic        rspFlag;
  logic [15:0] rspData;
  logic [31:0] busAddr;
  logic [1:0]  busSize;
  logic        busRead, busWrite;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic        busDone = 1'b0;
  logic        busErr = 1'b0;

  int checks = 0;
  int errors = 0;

  // bus responder bookkeeping
  bit          errInject = 1'b0;
  bit          busPending = 1'b0;
  int          busWait = 0;
  int          strobes = 0;
  logic [31:0] seenAddr = '0, seenWdata = '0;
  logic [1:0]  seenSize = '0;
  bit          seenWrite = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_engine u0 (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWord(cmdWord),
    .rspValid(rspValid), .rspReady(rspReady), .rspFlag(rspFlag), .rspData(rspData),
    .busAddr(busAddr), .busSize(busSize), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .busDone(busDone), .busErr(busErr)
  );

  function automatic logic [31:0] memData(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  function automatic logic [31:0] expAlign(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd1) return a & 32'hFFFF_FFFE;
    if (sz == 2'd2) return a & 32'hFFFF_FFFC;
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory / register file responder, random latency 0..3
  always @(negedge clk) begin
    busDone = 1'b0;
    busErr  = 1'b0;
    if (rstN && (busRead || busWrite)) begin
      if (!busPending) begin
        busPending = 1'b1;
        busWait    = $urandom % 4;
        seenAddr   = busAddr;
        seenSize   = busSize;
        seenWdata  = busWdata;
        seenWrite  = busWrite;
        strobes++;
      end
      if (busWait == 0) begin
        busDone  = 1'b1;
        busErr   = errInject;
        busRdata = memData(busAddr);
      end else begin
        busWait--;
      end
    end else begin
      busPending = 1'b0;
    end
  end

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = w;
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    #1 cmdValid = 1'b0;
  endtask

  task automatic getRsp(output logic [16:0] rsp);
    bit got = 1'b0;
    logic [16:0] first;
    while (!got) begin
      @(negedge clk);
      rspReady = 1'b0;
      if (rspValid) begin
        if (rspFlag && rspData == 16'h0000) begin
          chk("R7 no command while busy", {31'd0, cmdReady}, 32'd0);
          rspReady = 1'($urandom % 2);   // popping a poll word must not advance
        end else begin
          first = {rspFlag, rspData};
          repeat ($urandom % 3) @(negedge clk);
          chk("R10 response held", {15'd0, rspValid, rspFlag, rspData}, {15'd0, 1'b1, first});
          rsp = first;
          rspReady = 1'b1;
          @(posedge clk);
          #1 rspReady = 1'b0;
          got = 1'b1;
        end
      end
    end
  endtask

  task automatic chkIdle(input string tag);
    @(negedge clk);
    chk(tag, {30'd0, cmdReady, rspValid}, {30'd0, 2'b10});
  endtask

  task automatic doRead(input logic [1:0] sz, input logic [31:0] addr, input bit err);
    logic [16:0] r;
    logic [31:0] d, ea;
    int s0;
    logic [3:0] nib;
    nib = (sz == 2'd0) ? 4'h0 : (sz == 2'd1) ? 4'h4 : 4'h8;
    errInject = err;
    s0 = strobes;
    sendWord({4'h1, 4'h9, nib, 4'h0});
    sendWord(addr[31:16]);
    sendWord(addr[15:0]);
    getRsp(r);
    ea = expAlign(addr, sz);
    d  = memData(ea);
    chk("R1 one read strobe", strobes - s0, 1);
    chk("R1 read not write", {31'd0, seenWrite}, 32'd0);
    chk("R2 aligned address", seenAddr, ea);
    chk("R1 size code", {30'd0, seenSize}, {30'd0, sz});
    if (err) begin
      chk("R8 bus error response", {15'd0, r}, {15'd0, 17'h10001});
    end else if (sz == 2'd0) begin
      chk("R3 byte result", {15'd0, r}, {15'd0, 1'b0, 8'h00, d[7:0]});
    end else if (sz == 2'd1) begin
      chk("R4 word result", {15'd0, r}, {15'd0, 1'b0, d[15:0]});
    end else begin
      chk("R4 long upper half", {15'd0, r}, {15'd0, 1'b0, d[31:16]});
      getRsp(r);
      chk("R4 long lower half", {15'd0, r}, {15'd0, 1'b0, d[15:0]});
    end
    chkIdle(err ? "R8 idle after error" : "R10 idle after read");
    errInject = 1'b0;
  endtask

  task automatic doWrite(input bit isA, input logic [2:0] num, input logic [31:0] val,
                         input bit err);
    logic [16:0] r;
    int s0;
    errInject = err;
    s0 = strobes;
    sendWord({4'h2, 4'h8, 4'h0, isA, num});
    sendWord(val[31:16]);
    sendWord(val[15:0]);
    getRsp(r);
    chk("R5 one write strobe", strobes - s0, 1);
    chk("R5 write not read", {31'd0, seenWrite}, 32'd1);
    chk("R5 register index", seenAddr, {28'd0, isA, num});
    chk("R5 write value", seenWdata, val);
    chk("R5 write size", {30'd0, seenSize}, 32'd2);
    if (err) chk("R8 write error response", {15'd0, r}, {15'd0, 17'h10001});
    else     chk("R6 write complete", {15'd0, r}, {15'd0, 17'h0FFFF});
    chkIdle("R10 idle after write");
    errInject = 1'b0;
  endtask

  task automatic doIllegal(input logic [15:0] w);
    logic [16:0] r;
    int s0;
    s0 = strobes;
    sendWord(w);
    getRsp(r);
    chk("R9 illegal response", {15'd0, r}, {15'd0, 17'h1FFFF});
    chk("R9 no bus access", strobes - s0, 0);
    chkIdle("R9 idle after illegal");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd24601));
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {28'd0, cmdReady, rspValid, busRead, busWrite}, 32'b1000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 after release", {28'd0, cmdReady, rspValid, busRead, busWrite}, 32'b1000);

    // directed corners
    doRead(2'd0, 32'h1234_5677, 1'b0);   // byte: odd address kept (R2, R3)
    doRead(2'd1, 32'h89AB_CDEF, 1'b0);   // word: bit 0 cleared (R2)
    doRead(2'd2, 32'hFFFF_FFFF, 1'b0);   // long: bits 1:0 cleared (R2, R4)
    doRead(2'd2, 32'h0000_1003, 1'b1);   // long with bus error (R8)
    doWrite(1'b1, 3'd7, 32'hDEAD_BEEF, 1'b0);
    doWrite(1'b0, 3'd0, 32'h0123_4567, 1'b1);
    doIllegal(16'h1910);
    doIllegal(16'h19C0);
    doIllegal(16'h1901);
    doIllegal(16'h2818);
    doIllegal(16'hFFFF);

    // constrained random mix
    for (int i = 0; i < 80; i++) begin
      int kind;
      kind = $urandom % 10;
      if (kind < 6) begin
        int szr;
        szr = $urandom % 3;
        doRead(2'(szr), $urandom, ($urandom % 6) == 0);
      end else if (kind < 9) begin
        doWrite(1'($urandom % 2), 3'($urandom % 8), $urandom, ($urandom % 6) == 0);
      end else begin
        doIllegal(16'h3000 | 16'($urandom % 16'h1000));
      end
    end
    finishRun();
  end

endmodule